// File: doc/BRIEF.md
# Sign-Rectified Segmented Code Correlator

This block correlates a stream of signed chip-rate samples against a short binary spreading code. It returns two results. The first is the correlation over the most recent code period. The second is a long metric built from several back-to-back code periods. Before the per-period results are summed, each one is folded to its magnitude: a negative result is subtracted and a positive one is added. The data polarity that rides on each symbol therefore cannot cancel the peak of the long sum. If the per-period results were summed raw, symbols of opposite sign would cancel, and the metric would be of no use for synchronisation.

The correlation slides one sample at a time. Each accepted input sample recomputes every segment sum over the newest window. Both results appear one clock after the sample is accepted, and each has its own valid strobe. Peak picking and timing decisions belong to downstream logic. The code length, the number of segments and the sample width are parameters, and the output widths grow to match them.

Top module: `rect_seg_correlator`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, both valid strobes are low and both result ports read zero.
- R2: Each valid strobe is high for exactly the clock that follows a clock with `smp_valid_i` high. `part_valid_o` needs at least CODE_LEN (8) samples accepted since reset. `metric_valid_o` needs at least CODE_LEN×SEGMENTS (64) samples accepted since reset.
- R3: `part_o` is the signed sum over chip index j = 0..7 of ±x. Here x is the sample accepted 7−j samples before the newest, and code bit j = 1 means +x while bit j = 0 means −x. Window positions never filled since reset count as zero.
- R4: `metric_o` is the sum of the absolute values of the eight segment correlations. Segment s covers sample ages 8s to 8s+7 and uses the same chip mapping as R3.
- R5: A symbol-aligned, code-spread input of amplitude A gives a metric of 64·A for any pattern of symbol polarities.
- R6: A clock with `smp_valid_i` low leaves `part_o` and `metric_o` unchanged and drives both strobes low.
- R7: At full-scale input, with samples of −128 and +127, the results do not wrap. The partial reaches 128·n0 + 127·n1, where n0 and n1 are the counts of 0 and 1 chips. The metric reaches 8 times that.
- R8: A reset in the middle of a run clears the window and the fill count. Both strobes then wait again for 8 and 64 fresh samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | 8 | Signed chip-rate sample |
| part_valid_o | output | 1 | Strobe for `part_o` |
| part_o | output | 12 | Signed correlation over the newest code period |
| metric_valid_o | output | 1 | Strobe for `metric_o` |
| metric_o | output | 14 | Unsigned sum of rectified segment correlations |

## Verification
The first pattern is an unmodulated code-spread preamble, which fixes the chip order and the segment alignment. The second spreads symbols of mixed polarity with idle gaps between them; a missing rectification or a window that shifts on idle clocks shows up in this case. Full-scale samples expose any result width that is too narrow. Pseudo-random noise and a reset in mid-stream show whether the window and fill count restart as they should.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   function automatic int part_width(input int smp_w, input int code_len);
      return smp_w + $clog2(code_len) + 1;
   endfunction

   function automatic int mag_width(input int smp_w, input int code_len);
      return smp_w + $clog2(code_len);
   endfunction

   function automatic int metric_width(input int smp_w, input int code_len, input int segs);
      return smp_w + $clog2(code_len) + $clog2(segs);
   endfunction
endpackage

// File: rtl/rsc_sample_window.sv
module rsc_sample_window #(
   parameter int SMP_W    = 8,
   parameter int CODE_LEN = 8,
   parameter int SEGMENTS = 8,
   localparam int WIN_LEN = CODE_LEN * SEGMENTS,
   localparam int CNT_W   = $clog2(WIN_LEN + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid_i,
   input  logic [SMP_W-1:0]         smp_i,
   output logic [WIN_LEN*SMP_W-1:0] win_o,
   output logic                     seg_ok_o,
   output logic                     win_ok_o
);
   localparam int HIST_BITS = (WIN_LEN - 1) * SMP_W;

   logic [HIST_BITS-1:0] hist_q;
   logic [CNT_W-1:0]     cnt_q;

   assign win_o    = {hist_q, smp_i};
   assign seg_ok_o = cnt_q >= CNT_W'(CODE_LEN - 1);
   assign win_ok_o = cnt_q >= CNT_W'(WIN_LEN - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         cnt_q  <= '0;
      end else if (valid_i) begin
         hist_q <= win_o[HIST_BITS-1:0];
         if (cnt_q != CNT_W'(WIN_LEN))
            cnt_q <= cnt_q + 1'b1;
      end
   end

   p_count_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(WIN_LEN));

   p_full_implies_seg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      win_ok_o |-> seg_ok_o);
endmodule

// File: rtl/rsc_segment_dot.sv
module rsc_segment_dot #(
   parameter int              SMP_W    = 8,
   parameter int              CODE_LEN = 8,
   parameter logic [CODE_LEN-1:0] CODE = '1,
   localparam int PART_W = rsc_pkg::part_width(SMP_W, CODE_LEN)
) (
   input  logic [CODE_LEN*SMP_W-1:0] seg_i,
   output logic signed [PART_W-1:0]  part_o
);
   always_comb begin
      logic signed [PART_W-1:0] acc;
      acc = '0;
      for (int j = 0; j < CODE_LEN; j++) begin
         logic signed [SMP_W-1:0]  smp;
         logic signed [PART_W-1:0] ext;
         smp = $signed(seg_i[(CODE_LEN-1-j)*SMP_W +: SMP_W]);
         ext = PART_W'(smp);
         if (CODE[j]) acc = acc + ext;
         else         acc = acc - ext;
      end
      part_o = acc;
   end
endmodule

// File: rtl/rsc_rectify_sum.sv
module rsc_rectify_sum #(
   parameter int SMP_W    = 8,
   parameter int CODE_LEN = 8,
   parameter int SEGMENTS = 8,
   localparam int PART_W  = rsc_pkg::part_width(SMP_W, CODE_LEN),
   localparam int MAG_W   = rsc_pkg::mag_width(SMP_W, CODE_LEN),
   localparam int MET_W   = rsc_pkg::metric_width(SMP_W, CODE_LEN, SEGMENTS)
) (
   input  logic [SEGMENTS*PART_W-1:0] parts_i,
   output logic [MET_W-1:0]           metric_o
);
   logic [SEGMENTS*MAG_W-1:0] mags;

   for (genvar s = 0; s < SEGMENTS; s++) begin : g_mag
      logic signed [PART_W-1:0] p;
      logic        [PART_W-1:0] folded;
      assign p      = $signed(parts_i[s*PART_W +: PART_W]);
      assign folded = p[PART_W-1] ? $unsigned(-p) : $unsigned(p);
      assign mags[s*MAG_W +: MAG_W] = folded[MAG_W-1:0];
   end

   always_comb begin
      logic [MET_W-1:0] acc;
      acc = '0;
      for (int s = 0; s < SEGMENTS; s++)
         acc = acc + MET_W'(mags[s*MAG_W +: MAG_W]);
      metric_o = acc;
   end
endmodule

// File: rtl/rect_seg_correlator.sv
module rect_seg_correlator #(
   parameter int              SMP_W    = 8,
   parameter int              CODE_LEN = 8,
   parameter int              SEGMENTS = 8,
   parameter logic [CODE_LEN-1:0] CODE = 8'b0100_1101,
   localparam int PART_W  = rsc_pkg::part_width(SMP_W, CODE_LEN),
   localparam int MET_W   = rsc_pkg::metric_width(SMP_W, CODE_LEN, SEGMENTS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_valid_i,
   input  logic [SMP_W-1:0]         smp_i,
   output logic                     part_valid_o,
   output logic signed [PART_W-1:0] part_o,
   output logic                     metric_valid_o,
   output logic [MET_W-1:0]         metric_o
);
   localparam int WIN_LEN  = CODE_LEN * SEGMENTS;
   localparam int SEG_BITS = CODE_LEN * SMP_W;
   localparam int MAX_MAG  = CODE_LEN * (2 ** (SMP_W - 1));
   localparam int MAX_MET  = SEGMENTS * MAX_MAG;

   if (SMP_W < 2) begin : g_bad_smp
      $error("sample width must be at least 2");
   end
   if (CODE_LEN < 2 || (CODE_LEN & (CODE_LEN - 1)) != 0) begin : g_bad_code
      $error("code length must be a power of two of at least 2");
   end
   if (SEGMENTS < 1 || (SEGMENTS & (SEGMENTS - 1)) != 0) begin : g_bad_segs
      $error("segment count must be a power of two");
   end

   logic [WIN_LEN*SMP_W-1:0]   win;
   logic                       seg_ok, win_ok;
   logic [SEGMENTS*PART_W-1:0] parts;
   logic [MET_W-1:0]           metric_d;

   rsc_sample_window #(
      .SMP_W(SMP_W), .CODE_LEN(CODE_LEN), .SEGMENTS(SEGMENTS)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .valid_i(smp_valid_i), .smp_i(smp_i),
      .win_o(win), .seg_ok_o(seg_ok), .win_ok_o(win_ok)
   );

   for (genvar s = 0; s < SEGMENTS; s++) begin : g_seg
      rsc_segment_dot #(
         .SMP_W(SMP_W), .CODE_LEN(CODE_LEN), .CODE(CODE)
      ) u_dot (
         .seg_i(win[s*SEG_BITS +: SEG_BITS]),
         .part_o(parts[s*PART_W +: PART_W])
      );
   end

   rsc_rectify_sum #(
      .SMP_W(SMP_W), .CODE_LEN(CODE_LEN), .SEGMENTS(SEGMENTS)
   ) u_sum (
      .parts_i(parts), .metric_o(metric_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part_valid_o   <= 1'b0;
         metric_valid_o <= 1'b0;
         part_o         <= '0;
         metric_o       <= '0;
      end else begin
         part_valid_o   <= smp_valid_i && seg_ok;
         metric_valid_o <= smp_valid_i && win_ok;
         if (smp_valid_i) begin
            part_o   <= $signed(parts[PART_W-1:0]);
            metric_o <= metric_d;
         end
      end
   end

   p_part_after_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      part_valid_o |-> $past(smp_valid_i));

   p_metric_implies_part_r2: assert property (@(posedge clk) disable iff (!rst_n)
      metric_valid_o |-> part_valid_o);

   p_part_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(part_o) <= MAX_MAG) && (int'(part_o) >= -MAX_MAG));

   p_metric_covers_part_r4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(metric_o) >= ((int'(part_o) < 0) ? -int'(part_o) : int'(part_o)));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(smp_valid_i) |-> ($stable(part_o) && $stable(metric_o) && !metric_valid_o));

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(metric_o) <= MAX_MET);
endmodule

// File: tb/sim_rect_seg_correlator.sv
`timescale 1ns/1ps
module sim_rect_seg_correlator;
   localparam logic [7:0] CODE = 8'b0100_1101;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_valid_i = 1'b0;
   logic signed [7:0] smp_i = '0;
   logic              part_valid_o, metric_valid_o;
   logic signed [11:0] part_o;
   logic [13:0]       metric_o;

   rect_seg_correlator #(.CODE(CODE)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_i(smp_i),
      .part_valid_o(part_valid_o), .part_o(part_o),
      .metric_valid_o(metric_valid_o), .metric_o(metric_o)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;
   int hist[64];
   int cnt = 0;
   bit e_pv = 0, e_mv = 0;
   int e_part = 0, e_met = 0;
   bit [7:0] lfsr = 8'hA5;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int mpart(input int seg);
      int a = 0;
      for (int j = 0; j < 8; j++) begin
         int x = hist[seg*8 + 7 - j];
         a += CODE[j] ? x : -x;
      end
      return a;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 64; i++) hist[i] = 0;
      cnt = 0; e_pv = 0; e_mv = 0; e_part = 0; e_met = 0;
   endtask

   task automatic compare(input string ph);
      check(part_valid_o == e_pv, {"R2 part_valid ", ph}, part_valid_o, e_pv);
      check(metric_valid_o == e_mv, {"R2 metric_valid ", ph}, metric_valid_o, e_mv);
      check(int'(part_o) == e_part, {"R3 part ", ph}, int'(part_o), e_part);
      check(int'(metric_o) == e_met, {"R4 metric ", ph}, int'(metric_o), e_met);
   endtask

   task automatic step(input bit v, input int s, input string ph);
      @(negedge clk);
      compare(ph);
      smp_valid_i = v;
      smp_i = 8'(s);
      if (v) begin
         for (int i = 63; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = s;
         if (cnt < 64) cnt++;
         e_pv = (cnt >= 8);
         e_mv = (cnt >= 64);
         e_part = mpart(0);
         e_met = 0;
         for (int g = 0; g < 8; g++) begin
            int p = mpart(g);
            e_met += (p < 0) ? -p : p;
         end
      end else begin
         e_pv = 0; e_mv = 0;
      end
   endtask

   task automatic send_symbol(input int pol, input int amp, input string ph);
      for (int j = 0; j < 8; j++) step(1, pol * (CODE[j] ? amp : -amp), ph);
   endtask

   task automatic do_reset(input string ph);
      @(negedge clk);
      rst_n = 0; smp_valid_i = 0;
      model_clear();
      repeat (2) begin
         @(negedge clk);
         check(!part_valid_o && !metric_valid_o, {"R1 strobes in reset ", ph},
               int'(part_valid_o) + int'(metric_valid_o), 0);
         check(part_o == 0 && metric_o == 0, {"R1 results in reset ", ph},
               int'(metric_o), 0);
      end
      rst_n = 1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL R2 watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_clear();
      do_reset("R1");
      step(0, 0, "R1 first clock after release");

      // preamble, all symbols +1, amplitude 40
      for (int k = 0; k < 9; k++) send_symbol(1, 40, "R2 R3 preamble");
      step(0, 0, "R6 idle");
      check(int'(metric_o) == 2560, "R5 preamble metric", int'(metric_o), 2560);

      // modulated symbols with idle gaps
      for (int k = 0; k < 10; k++) begin
         int pol = ((k * 5 + 3) % 3 == 0) ? -1 : 1;
         send_symbol(pol, 40, "R5 modulated");
         if (k % 3 == 1) begin
            step(0, 0, "R6 gap");
            step(0, 0, "R6 gap");
         end
      end
      step(0, 0, "R6 idle after modulated");
      check(int'(metric_o) == 2560, "R5 polarity-invariant metric", int'(metric_o), 2560);
      check(int'(part_o) == -320 || int'(part_o) == 320, "R3 aligned partial magnitude",
            int'(part_o), 320);
      step(0, 0, "R6 second idle");
      check(int'(metric_o) == 2560 && !metric_valid_o, "R6 held metric",
            int'(metric_o), 2560);

      // full-scale input
      for (int k = 0; k < 8; k++)
         for (int j = 0; j < 8; j++) step(1, CODE[j] ? 127 : -128, "R7 full scale");
      step(0, 0, "R7 idle");
      check(int'(part_o) == 1020, "R7 full-scale partial", int'(part_o), 1020);
      check(int'(metric_o) == 8160, "R7 full-scale metric", int'(metric_o), 8160);

      // pseudo-random noise with sparse idles
      for (int k = 0; k < 200; k++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         step(k % 7 != 3, int'($signed(lfsr)), "R3 R4 noise");
      end

      // reset during a run, then refill
      do_reset("R8");
      step(0, 0, "R8 release");
      for (int k = 0; k < 70; k++) begin
         step(1, (k % 11) * 9 - 45, "R8 refill");
         if (k == 6 || k == 62) begin
            step(0, 0, "R8 boundary");
            check(k == 6 ? !part_valid_o : !metric_valid_o, "R8 strobe before fill",
                  k == 6 ? int'(part_valid_o) : int'(metric_valid_o), 0);
         end
      end
      step(0, 0, "R8 end");
      step(0, 0, "R6 end");

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule